// File: doc/BRIEF.md
# Interrupt Acknowledge Priority Chain

This block collects interrupt requests from a fixed set of sources and answers a processor's interrupt-acknowledge cycle. Each source sits at one position of a priority chain. A source raises a request, and the block latches that request together with a small status word. When an acknowledge arrives, the source nearest the head of the chain that has a request pending answers it. That source puts its own unit address and its latched status on the response, and its request is cleared. The acknowledge carries no target address. The responder identifies itself.

The chain order comes from a configuration parameter, `CHAIN_MAP`. It is independent of source numbering. Chain position p is served by source `CHAIN_MAP[p*IDX_W +: IDX_W]`, and position 0 has the highest priority. Every response comes back one clock after the acknowledge and carries a condition code that says whether a source answered. It also carries a register-write strobe for the destination register field given with the acknowledge. The top also outputs the priority signal that leaves the last position, so that a further chain can be cascaded behind this one.

Top module: `irq_ack_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending request is dropped and all response outputs go to zero. After reset, `chain_pass_o` is 1.
- R2: A high `req_set_i[s]` at a clock edge makes source s pending and latches `req_status_i[s*STAT_W +: STAT_W]` as its status.
- R3: An acknowledge with `ack_valid_i` high is standard only when `ack_addr_i[13:8]` is all zero. Bits [7:0] and [31:14] of `ack_addr_i` have no effect on the outcome.
- R4: An acknowledge with a nonzero `ack_addr_i[13:8]` is reserved. Its response has `rsp_cc_o` = 2'b10, zero data, `rsp_wr_en_o` = 0 and `rsp_wr_reg_o` = 0. It leaves every pending request and status unchanged.
- R5: On a standard acknowledge, only the pending source at the lowest chain position answers. Chain order follows `CHAIN_MAP`, not source index.
- R6: The answer has `rsp_cc_o` = 2'b01 and `rsp_data_o` = {unit address of the source, its latched status}, with the unit address in the upper bits.
- R7: The answering source stops being pending at the same edge that registers its response. A set for that source at that same edge wins, and the set latches the new status.
- R8: A standard acknowledge with no source pending gives `rsp_cc_o` = 2'b00 and `rsp_data_o` = 0.
- R9: `rsp_valid_o` is high exactly in the cycle after an acknowledge. `rsp_wr_en_o` is high only for a standard acknowledge whose `ack_rfield_i` is nonzero. `rsp_wr_reg_o` echoes that field for a standard acknowledge and is otherwise 0.
- R10: `chain_pass_o` is high exactly when no source is pending. Priority passes a position only if it arrives there and that position has no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set_i | input | N_STAGES | Per-source request strobe |
| req_status_i | input | N_STAGES*STAT_W | Per-source status latched with the request |
| unit_addr_i | input | N_STAGES*UADDR_W | Per-source unit address (static configuration) |
| ack_valid_i | input | 1 | Acknowledge cycle strobe |
| ack_addr_i | input | 32 | Acknowledge effective address; [13:8] is the selection field |
| ack_rfield_i | input | RF_W | Destination register field of the acknowledge |
| rsp_valid_o | output | 1 | Response present |
| rsp_cc_o | output | 2 | 00 nothing answered, 01 answered, 10 reserved selection |
| rsp_data_o | output | UADDR_W+STAT_W | {unit address, status} of the responder, else 0 |
| rsp_wr_en_o | output | 1 | Register write strobe |
| rsp_wr_reg_o | output | RF_W | Register number to write |
| chain_pass_o | output | 1 | Priority leaving the last chain position |

## Verification
The bench sets requests in several sources at once and drains them one acknowledge at a time. A chain ordered by source index instead of `CHAIN_MAP` would answer in the wrong order. A chain that does not block lower positions would answer with two sources ORed together. It drives reserved selection codes and then a standard acknowledge, which catches a design that clears a request on a reserved cycle, since that request would then never be answered. It also raises a new request for the answering source in the acknowledge cycle, where a clear that beats the set would lose the request. Register fields of zero and acknowledges with nothing pending show whether the write strobe and the zero data follow the rules.

// File: rtl/irq_ack_pkg.sv
// Shared constants and types for the interrupt acknowledge chain.
// Assumes a 32-bit acknowledge address whose selection field is [13:8].
package irq_ack_pkg;

    localparam int ACK_ADDR_W = 32;
    localparam int SEL_LSB    = 8;
    localparam int SEL_W      = 6;

    // Condition code returned with every response.
    typedef enum logic [1:0] {
        CC_NONE     = 2'b00,
        CC_FOUND    = 2'b01,
        CC_RESERVED = 2'b10
    } ack_cc_e;

endpackage

// File: rtl/ack_sel_decode.sv
// Classifies an acknowledge cycle as standard or reserved.
// Assumes the caller passes only the selection field; other address
// bits take no part in the decision.
module ack_sel_decode
    import irq_ack_pkg::*;
(
    input  logic             ack_valid_i,
    input  logic [SEL_W-1:0] sel_field_i,
    output logic             std_ack_o,
    output logic             rsv_ack_o
);

    // Standard only for an all-zero selection field, reserved otherwise.
    always_comb begin
        std_ack_o = ack_valid_i && (sel_field_i == '0);
        rsv_ack_o = ack_valid_i && (sel_field_i != '0);
    end

endmodule

// File: rtl/chain_stage.sv
// One position of the priority chain: holds the pending flag and status
// of the source mapped to it, answers when priority reaches it during a
// standard acknowledge, and passes priority on only when idle.
// Assumes set_i and status_i are synchronous to clk.
module chain_stage #(
    parameter int STAT_W  = 4,
    parameter int UADDR_W = 8,
    localparam int WORD_W = UADDR_W + STAT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pri_in_i,
    input  logic               ack_std_i,
    input  logic               set_i,
    input  logic [STAT_W-1:0]  status_i,
    input  logic [UADDR_W-1:0] unit_addr_i,
    output logic               pri_out_o,
    output logic               grant_o,
    output logic [WORD_W-1:0]  word_o
);

    logic              pending_q;
    logic [STAT_W-1:0] status_q;

    // Grant and priority pass-through for this position.
    always_comb begin
        grant_o   = pri_in_i && pending_q && ack_std_i;
        pri_out_o = pri_in_i && !pending_q;
        word_o    = grant_o ? {unit_addr_i, status_q} : '0;
    end

    // Pending flag and status: grant clears, a new set overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            status_q  <= '0;
        end else begin
            if (grant_o) begin
                pending_q <= 1'b0;
            end
            if (set_i) begin
                pending_q <= 1'b1;
                status_q  <= status_i;
            end
        end
    end

    // R7: an answered request without a fresh set is gone next cycle.
    a_r7_clear_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o && !set_i |=> !pending_q);

    // R2: a set leaves the stage pending with the offered status.
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pending_q && (status_q == $past(status_i)));

    // R4/R5: a stage without a standard acknowledge keeps its request.
    a_r4_hold_without_std: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q && !ack_std_i |=> pending_q);

endmodule

// File: rtl/response_capture.sv
// Registers the response of an acknowledge: validity, condition code,
// data word, and the register-write strobe with its register number.
// Assumes the data word is already zero when no stage answered.
module response_capture
    import irq_ack_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int RF_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_ack_i,
    input  logic              rsv_ack_i,
    input  logic              any_grant_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [RF_W-1:0]   rfield_i,
    output logic              rsp_valid_o,
    output ack_cc_e           rsp_cc_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              rsp_wr_en_o,
    output logic [RF_W-1:0]   rsp_wr_reg_o
);

    // Response registers, all zero between acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o  <= 1'b0;
            rsp_cc_o     <= CC_NONE;
            rsp_data_o   <= '0;
            rsp_wr_en_o  <= 1'b0;
            rsp_wr_reg_o <= '0;
        end else if (std_ack_i) begin
            rsp_valid_o  <= 1'b1;
            rsp_cc_o     <= any_grant_i ? CC_FOUND : CC_NONE;
            rsp_data_o   <= word_i;
            rsp_wr_en_o  <= (rfield_i != '0);
            rsp_wr_reg_o <= rfield_i;
        end else if (rsv_ack_i) begin
            rsp_valid_o  <= 1'b1;
            rsp_cc_o     <= CC_RESERVED;
            rsp_data_o   <= '0;
            rsp_wr_en_o  <= 1'b0;
            rsp_wr_reg_o <= '0;
        end else begin
            rsp_valid_o  <= 1'b0;
            rsp_cc_o     <= CC_NONE;
            rsp_data_o   <= '0;
            rsp_wr_en_o  <= 1'b0;
            rsp_wr_reg_o <= '0;
        end
    end

    // R4: a reserved cycle writes nothing and returns no data.
    a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && (rsp_cc_o == CC_RESERVED) |-> !rsp_wr_en_o && (rsp_data_o == '0));

    // R8: nothing answered means zero data.
    a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cc_o == CC_NONE |-> rsp_data_o == '0);

    // R9: the write strobe needs a response and a nonzero register.
    a_r9_write_needs_reg: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en_o |-> rsp_valid_o && (rsp_wr_reg_o != '0));

    // R9: a response appears only after an acknowledge.
    a_r9_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (std_ack_i || rsv_ack_i) |=> rsp_valid_o);

endmodule

// File: rtl/irq_ack_chain.sv
// Interrupt acknowledge responder built from a configurable priority
// chain. Position p of the chain serves source CHAIN_MAP[p]; position 0
// is highest. Assumes CHAIN_MAP is a permutation of 0..N_STAGES-1 and
// that unit_addr_i is static configuration.
module irq_ack_chain
    import irq_ack_pkg::*;
#(
    parameter int N_STAGES = 4,
    parameter int STAT_W   = 4,
    parameter int UADDR_W  = 8,
    parameter int RF_W     = 4,
    parameter int IDX_W    = $clog2(N_STAGES),
    parameter logic [N_STAGES*IDX_W-1:0] CHAIN_MAP = 8'h72
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_STAGES-1:0]           req_set_i,
    input  logic [N_STAGES*STAT_W-1:0]    req_status_i,
    input  logic [N_STAGES*UADDR_W-1:0]   unit_addr_i,
    input  logic                          ack_valid_i,
    input  logic [ACK_ADDR_W-1:0]         ack_addr_i,
    input  logic [RF_W-1:0]               ack_rfield_i,
    output logic                          rsp_valid_o,
    output logic [1:0]                    rsp_cc_o,
    output logic [UADDR_W+STAT_W-1:0]     rsp_data_o,
    output logic                          rsp_wr_en_o,
    output logic [RF_W-1:0]               rsp_wr_reg_o,
    output logic                          chain_pass_o
);

    localparam int DATA_W = UADDR_W + STAT_W;

    logic                std_ack;
    logic                rsv_ack;
    logic [N_STAGES:0]   pri;
    logic [N_STAGES-1:0] grant_pos;
    logic [DATA_W-1:0]   word_pos [N_STAGES];
    logic [DATA_W-1:0]   word_or;
    logic                any_grant;
    ack_cc_e             cc_q;
    logic                unused_addr_bits;

    assign unused_addr_bits = ^{ack_addr_i[ACK_ADDR_W-1:SEL_LSB+SEL_W], ack_addr_i[SEL_LSB-1:0]};

    ack_sel_decode u_decode (
        .ack_valid_i (ack_valid_i),
        .sel_field_i (ack_addr_i[SEL_LSB +: SEL_W]),
        .std_ack_o   (std_ack),
        .rsv_ack_o   (rsv_ack)
    );

    assign pri[0] = 1'b1;

    for (genvar p = 0; p < N_STAGES; p++) begin : g_pos
        localparam int SRC = int'(CHAIN_MAP[p*IDX_W +: IDX_W]);
        chain_stage #(
            .STAT_W  (STAT_W),
            .UADDR_W (UADDR_W)
        ) u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .pri_in_i    (pri[p]),
            .ack_std_i   (std_ack),
            .set_i       (req_set_i[SRC]),
            .status_i    (req_status_i[SRC*STAT_W +: STAT_W]),
            .unit_addr_i (unit_addr_i[SRC*UADDR_W +: UADDR_W]),
            .pri_out_o   (pri[p+1]),
            .grant_o     (grant_pos[p]),
            .word_o      (word_pos[p])
        );
    end

    // Merge the per-position words; at most one is nonzero.
    always_comb begin
        word_or = '0;
        for (int p = 0; p < N_STAGES; p++) begin
            word_or = word_or | word_pos[p];
        end
        any_grant = |grant_pos;
    end

    response_capture #(
        .DATA_W (DATA_W),
        .RF_W   (RF_W)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .std_ack_i    (std_ack),
        .rsv_ack_i    (rsv_ack),
        .any_grant_i  (any_grant),
        .word_i       (word_or),
        .rfield_i     (ack_rfield_i),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_cc_o     (cc_q),
        .rsp_data_o   (rsp_data_o),
        .rsp_wr_en_o  (rsp_wr_en_o),
        .rsp_wr_reg_o (rsp_wr_reg_o)
    );

    assign rsp_cc_o     = cc_q;
    assign chain_pass_o = pri[N_STAGES];

    // R5: never more than one responder.
    a_r5_single_responder: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_pos));

    // R4: a reserved selection grants nobody.
    a_r4_no_grant_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_ack |-> grant_pos == '0);

    // R5/R8: a standard acknowledge answers whenever anything is pending.
    a_r5_answer_if_pending: assert property (@(posedge clk) disable iff (!rst_n)
        std_ack && !chain_pass_o |-> any_grant);

    // R6: a found response carries a nonzero-source word from the chain.
    a_r6_found_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
        any_grant |=> rsp_valid_o && (rsp_cc_o == 2'b01));

endmodule

// File: tb/irq_ack_chain_tb_top.sv
`timescale 1ns/1ps
module irq_ack_chain_tb_top;

    localparam int N  = 4;
    localparam int SW = 4;
    localparam int AW = 8;
    localparam int RW = 4;
    localparam int ORDER [N] = '{2, 0, 3, 1};

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     req_set;
    logic [N*SW-1:0]  req_status;
    logic [N*AW-1:0]  unit_addr;
    logic             ack_valid;
    logic [31:0]      ack_addr;
    logic [RW-1:0]    ack_rfield;
    logic             rsp_valid;
    logic [1:0]       rsp_cc;
    logic [AW+SW-1:0] rsp_data;
    logic             rsp_wr_en;
    logic [RW-1:0]    rsp_wr_reg;
    logic             chain_pass;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  m_pend [N];
    logic [SW-1:0] m_stat [N];

    always #4 clk = ~clk;

    irq_ack_chain dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_set_i    (req_set),
        .req_status_i (req_status),
        .unit_addr_i  (unit_addr),
        .ack_valid_i  (ack_valid),
        .ack_addr_i   (ack_addr),
        .ack_rfield_i (ack_rfield),
        .rsp_valid_o  (rsp_valid),
        .rsp_cc_o     (rsp_cc),
        .rsp_data_o   (rsp_data),
        .rsp_wr_en_o  (rsp_wr_en),
        .rsp_wr_reg_o (rsp_wr_reg),
        .chain_pass_o (chain_pass)
    );

    function automatic logic [AW-1:0] unit_of(input int s);
        return 8'h40 + 8'(s * 17);
    endfunction

    // Highest-priority pending source per the configured order, or -1.
    function automatic int winner();
        for (int p = 0; p < N; p++) begin
            if (m_pend[ORDER[p]]) return ORDER[p];
        end
        return -1;
    endfunction

    function automatic bit none_pending();
        for (int s = 0; s < N; s++) if (m_pend[s]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model the edge, check at next negedge.
    task automatic step(input logic [N-1:0] set, input logic [N*SW-1:0] st,
                        input logic av, input logic [31:0] addr,
                        input logic [RW-1:0] rf, input string tag);
        bit std, rsv;
        int w;
        logic [1:0]       e_cc;
        logic [AW+SW-1:0] e_data;
        std = av && (addr[13:8] == 6'd0);
        rsv = av && !std;
        w   = std ? winner() : -1;
        e_cc   = !av ? 2'b00 : (rsv ? 2'b10 : ((w >= 0) ? 2'b01 : 2'b00));
        e_data = (w >= 0) ? {unit_of(w), m_stat[w]} : '0;
        req_set    = set;
        req_status = st;
        ack_valid  = av;
        ack_addr   = addr;
        ack_rfield = rf;
        @(posedge clk);
        if (w >= 0) m_pend[w] = 1'b0;
        for (int s = 0; s < N; s++) begin
            if (set[s]) begin
                m_pend[s] = 1'b1;
                m_stat[s] = st[s*SW +: SW];
            end
        end
        @(negedge clk);
        req_set   = '0;
        ack_valid = 1'b0;
        chk(rsp_valid == av, {"R9 valid ", tag}, 32'(rsp_valid), 32'(av));
        chk(rsp_cc == e_cc, {"cc ", tag}, 32'(rsp_cc), 32'(e_cc));
        chk(rsp_data == e_data, {"data ", tag}, 32'(rsp_data), 32'(e_data));
        chk(rsp_wr_en == (std && rf != 0), {"R9 wr_en ", tag}, 32'(rsp_wr_en), 32'(std && rf != 0));
        chk(rsp_wr_reg == (std ? rf : '0), {"R9 wr_reg ", tag}, 32'(rsp_wr_reg), 32'(std ? rf : '0));
        chk(chain_pass == none_pending(), {"R10 pass ", tag}, 32'(chain_pass), 32'(none_pending()));
    endtask

    bit done = 1'b0;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < N; s++) begin
            unit_addr[s*AW +: AW] = unit_of(s);
            m_pend[s] = 1'b0;
            m_stat[s] = '0;
        end
        rst_n = 1'b0; req_set = '0; req_status = '0;
        ack_valid = 1'b0; ack_addr = '0; ack_rfield = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(rsp_valid == 1'b0 && rsp_data == '0 && rsp_cc == 2'b00, "R1 outputs", 32'(rsp_data), 0);
        chk(chain_pass == 1'b1, "R1 pass", 32'(chain_pass), 1);

        // R8: nothing pending
        step('0, '0, 1'b1, 32'h0, 4'd3, "R8 empty");
        // R2/R3/R5/R6: fill all, drain in configured order with junk address bits
        step(4'b1111, 16'h4321, 1'b0, 32'h0, 4'd0, "R2 fill");
        step('0, '0, 1'b1, 32'hFFFFC0FF, 4'd5, "R3 R5 R6 first");
        step('0, '0, 1'b1, 32'h12340077, 4'd1, "R5 second");
        step('0, '0, 1'b1, 32'hABCD00AA, 4'd0, "R5 third");
        step('0, '0, 1'b1, 32'h0, 4'd2, "R5 fourth");
        step('0, '0, 1'b1, 32'h0, 4'd2, "R8 drained");
        // R4: reserved codings leave the request in place
        step(4'b0010, 16'h00A0, 1'b0, 32'h0, 4'd0, "R2 set one");
        step('0, '0, 1'b1, 32'h00000100, 4'd7, "R4 bit8");
        step('0, '0, 1'b1, 32'h00002000, 4'd7, "R4 bit13");
        step('0, '0, 1'b1, 32'h0, 4'd0, "R4 still pending");
        // R7: set on the answering source in the acknowledge cycle
        step(4'b0100, 16'h0500, 1'b0, 32'h0, 4'd0, "R7 prep");
        step(4'b0100, 16'h0900, 1'b1, 32'h0, 4'd4, "R7 set and grant");
        step('0, '0, 1'b1, 32'h0, 4'd4, "R7 new status");
        step('0, '0, 1'b0, 32'h0, 4'd0, "R9 idle");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [N-1:0]    set;
            logic [31:0]     addr;
            set  = ($urandom % 3 == 0) ? 4'($urandom) : '0;
            addr = $urandom;
            if ($urandom % 10 < 7) addr[13:8] = 6'd0;
            step(set, 16'($urandom), 1'($urandom), addr, 4'($urandom), "R5 R7 random");
        end
        finish_run();
    end

endmodule